// File: doc/BRIEF.md
# Memory Ordering Barrier Unit

This unit gates issue between an out-of-order memory pipeline and its load and store ports. Every issued load or store is counted against the epoch that is open when it issues. A barrier closes the current epoch and opens a new one. A four-bit ordering mask on the barrier selects which classes of earlier operations must complete before which classes of later operations may issue. Classes the mask does not select cross the barrier freely. Two shorthand barrier kinds are also accepted: a full barrier, and a writes-only barrier that orders stores against stores. A separate synchronization operation gives weak-ordering behaviour: it waits until every earlier operation has drained, and it holds back all data issue until it completes.

The pipeline reads `ld_allow`, `st_allow` and `sync_allow` before it issues. It tags each issued operation with `iss_tag` and hands that tag back with the completion pulse. Addresses, data and caches stay outside the unit.

Top module: `ord_barrier_unit`

## Requirements
- R1: After reset, `ld_allow`, `st_allow`, `sync_allow` and `bar_ready` are 1, `iss_tag` is 0, and no operation or barrier is pending.
- R2: Barrier mask bit positions (earlier class before later class) are: bit 0 load→load, bit 1 load→store, bit 2 store→load, bit 3 store→store. A later class is held low while any pending barrier selects it against an earlier class that still has operations outstanding in the epochs at or before that barrier.
- R3: A later class that no pending barrier selects keeps its allow signal high while the barrier waits.
- R4: `bar_kind` 1 is a full barrier and behaves exactly like mask 4'b1111.
- R5: `bar_kind` 2 is a writes-only barrier. It holds later stores until earlier stores complete and places no constraint on loads. `bar_kind` 0 uses `bar_mask`.
- R6: A completion pulse decrements the count of the epoch named by its tag. An allow signal rises in the first cycle after the clock edge that takes the last ordering completion.
- R7: At most two barriers may be pending, and `bar_ready` is low while two are pending. A pending barrier is reclaimed, oldest first, one clock edge after its epoch holds no outstanding load or store.
- R8: `sync_allow` is high only when no load, store or synchronization operation is outstanding. `iss_kind` encoding is 0 load, 1 store, 2 sync. While a sync is outstanding, `ld_allow` and `st_allow` are low until `sync_done`.
- R9: With no barrier pending and no sync outstanding, loads and stores issue and complete in any order, and their allow signals stay high.
- R10: Each epoch counts at most 15 loads and 15 stores. The allow for a class is low while the open epoch holds 15 outstanding operations of that class.
- R11: `iss_tag` names the open epoch slot (0..2). It advances by one, modulo 3, on each accepted barrier. An operation issued in the same cycle as a barrier belongs to the epoch the barrier closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An operation issues this cycle |
| iss_kind | input | 2 | 0 load, 1 store, 2 sync |
| iss_tag | output | 2 | Epoch slot that a data operation issued now belongs to |
| bar_valid | input | 1 | Barrier request |
| bar_kind | input | 2 | 0 masked, 1 full, 2 writes-only |
| bar_mask | input | 4 | Ordering mask used when `bar_kind` is 0 |
| bar_ready | output | 1 | A barrier can be accepted |
| ld_done | input | 1 | A load completes |
| ld_done_tag | input | 2 | Epoch tag of the completing load |
| st_done | input | 1 | A store completes |
| st_done_tag | input | 2 | Epoch tag of the completing store |
| sync_done | input | 1 | The outstanding sync completes |
| ld_allow | output | 1 | A load may issue |
| st_allow | output | 1 | A store may issue |
| sync_allow | output | 1 | A sync may issue |

## Verification
The assertions take for granted that the pipeline issues an operation only when its allow signal is high, offers a barrier only while `bar_ready` is high, and returns each completion with the tag it received at issue, exactly once. The stimulus stays inside that contract. Directed sequences drive single operations into known states. The random phase issues a class only after it has read the matching allow at the falling edge, and it keeps a table of outstanding operations from which completions are drawn after random delays. On every random issue, the bench looks for an outstanding earlier operation that a recorded barrier orders the new operation after.

// File: rtl/obu_pkg.sv
// Package: shared encodings for the ordering barrier unit.
// Assumes: the mask bit index is (earlier class * 2 + later class), load = 0, store = 1.
package obu_pkg;
    typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_SYNC = 2'd2} op_kind_e;
    typedef enum logic [1:0] {BK_MASKED = 2'd0, BK_FULL = 2'd1, BK_WRITES = 2'd2} bar_kind_e;

    localparam int ORD_LL = 0;
    localparam int ORD_LS = 1;
    localparam int ORD_SL = 2;
    localparam int ORD_SS = 3;

    // Resolve a barrier kind to the effective four-bit ordering mask.
    function automatic logic [3:0] eff_mask(input logic [1:0] kind, input logic [3:0] m);
        case (kind)
            BK_FULL:   return 4'b1111;
            BK_WRITES: return 4'b1000;
            default:   return m;
        endcase
    endfunction
endpackage

// File: rtl/epoch_slot.sv
// Module: one epoch slot. It holds the outstanding load and store counts of one
// epoch and the ordering mask of the barrier that closed it.
// Assumes: the parent never increments a full counter and never decrements an empty one.
module epoch_slot #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_inc,
    input  logic             ld_dec,
    input  logic             st_inc,
    input  logic             st_dec,
    input  logic             mask_set,
    input  logic [3:0]       mask_in,
    output logic [CNT_W-1:0] ld_cnt,
    output logic [CNT_W-1:0] st_cnt,
    output logic [3:0]       mask
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Track outstanding loads of this epoch.
    always_ff @(posedge clk) begin
        if (!rst_n)                ld_cnt <= '0;
        else if (ld_inc && !ld_dec) ld_cnt <= ld_cnt + 1'b1;
        else if (ld_dec && !ld_inc) ld_cnt <= ld_cnt - 1'b1;
    end

    // Track outstanding stores of this epoch.
    always_ff @(posedge clk) begin
        if (!rst_n)                st_cnt <= '0;
        else if (st_inc && !st_dec) st_cnt <= st_cnt + 1'b1;
        else if (st_dec && !st_inc) st_cnt <= st_cnt - 1'b1;
    end

    // Capture the mask of the barrier that closes this epoch.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask <= '0;
        else if (mask_set) mask <= mask_in;
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_inc && !ld_dec) |-> (ld_cnt != CNT_MAX));
    assert_no_st_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_inc && !st_dec) |-> (st_cnt != CNT_MAX));
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_dec && !ld_inc) |-> (ld_cnt != '0));
    assert_no_st_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_dec && !st_inc) |-> (st_cnt != '0));
endmodule

// File: rtl/order_gate.sv
// Module: combinational blocking decision. It walks the pending barriers from
// oldest to youngest, accumulates which earlier classes are still outstanding,
// and blocks each later class that some barrier orders after them.
// Assumes: slots head .. head+nbar-1 (mod NSLOT) are closed by pending barriers.
module order_gate #(
    parameter int CNT_W   = 4,
    parameter int MAX_BAR = 2,
    parameter int NSLOT   = MAX_BAR + 1,
    parameter int TAG_W   = 2,
    parameter int NB_W    = 2
) (
    input  logic [TAG_W-1:0]            head,
    input  logic [NB_W-1:0]             nbar,
    input  logic [NSLOT-1:0][CNT_W-1:0] ld_cnt,
    input  logic [NSLOT-1:0][CNT_W-1:0] st_cnt,
    input  logic [NSLOT-1:0][3:0]       mask,
    output logic                        blk_ld,
    output logic                        blk_st
);
    import obu_pkg::*;

    // Accumulate earlier outstanding classes and apply each pending mask.
    always_comb begin
        logic any_ld;
        logic any_st;
        any_ld = 1'b0;
        any_st = 1'b0;
        blk_ld = 1'b0;
        blk_st = 1'b0;
        for (int i = 0; i < MAX_BAR; i++) begin
            int idx;
            idx = (int'(head) + i) % NSLOT;
            if (i < int'(nbar)) begin
                any_ld = any_ld | (ld_cnt[idx] != '0);
                any_st = any_st | (st_cnt[idx] != '0);
                if ((mask[idx][ORD_LL] && any_ld) || (mask[idx][ORD_SL] && any_st)) blk_ld = 1'b1;
                if ((mask[idx][ORD_LS] && any_ld) || (mask[idx][ORD_SS] && any_st)) blk_st = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ord_barrier_unit.sv
// Module: top of the memory ordering barrier unit. It owns the ring of epoch
// slots, the barrier window (head, count), the sync state and the allow outputs.
// Assumes: callers issue only when allowed, offer barriers only when ready and
// return every completion once, with its issue tag.
module ord_barrier_unit #(
    parameter int CNT_W   = 4,
    parameter int MAX_BAR = 2,
    localparam int NSLOT  = MAX_BAR + 1,
    localparam int TAG_W  = $clog2(NSLOT),
    localparam int NB_W   = $clog2(MAX_BAR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [1:0]       iss_kind,
    output logic [TAG_W-1:0] iss_tag,
    input  logic             bar_valid,
    input  logic [1:0]       bar_kind,
    input  logic [3:0]       bar_mask,
    output logic             bar_ready,
    input  logic             ld_done,
    input  logic [TAG_W-1:0] ld_done_tag,
    input  logic             st_done,
    input  logic [TAG_W-1:0] st_done_tag,
    input  logic             sync_done,
    output logic             ld_allow,
    output logic             st_allow,
    output logic             sync_allow
);
    import obu_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [NB_W-1:0]  NB_LIMIT = NB_W'(MAX_BAR);

    logic [TAG_W-1:0]            head;
    logic [NB_W-1:0]             nbar;
    logic                        sync_busy;
    logic [TAG_W-1:0]            open_slot;
    logic [NSLOT-1:0][CNT_W-1:0] ld_cnt;
    logic [NSLOT-1:0][CNT_W-1:0] st_cnt;
    logic [NSLOT-1:0][3:0]       slot_mask;
    logic                        blk_ld;
    logic                        blk_st;
    logic                        retire;
    logic                        bar_take;
    logic                        all_idle;
    logic                        iss_ld;
    logic                        iss_st;
    logic                        iss_sy;

    // Add an offset to a slot index, wrapping over the ring.
    function automatic logic [TAG_W-1:0] ring_add(input logic [TAG_W-1:0] a, input int b);
        return TAG_W'((int'(a) + b) % NSLOT);
    endfunction

    // Decode issue kind and the barrier handshake.
    always_comb begin
        iss_ld   = iss_valid && (iss_kind == OP_LOAD);
        iss_st   = iss_valid && (iss_kind == OP_STORE);
        iss_sy   = iss_valid && (iss_kind == OP_SYNC);
        bar_take = bar_valid && bar_ready;
    end

    // Locate the open epoch and decide whether the oldest barrier can be reclaimed.
    always_comb begin
        open_slot = ring_add(head, int'(nbar));
        retire    = (nbar != '0) && (ld_cnt[head] == '0) && (st_cnt[head] == '0);
        all_idle  = 1'b1;
        for (int k = 0; k < NSLOT; k++)
            if (ld_cnt[k] != '0 || st_cnt[k] != '0) all_idle = 1'b0;
    end

    // One counter slot per epoch in the ring.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        epoch_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_inc   (iss_ld && (open_slot == TAG_W'(s))),
            .ld_dec   (ld_done && (ld_done_tag == TAG_W'(s))),
            .st_inc   (iss_st && (open_slot == TAG_W'(s))),
            .st_dec   (st_done && (st_done_tag == TAG_W'(s))),
            .mask_set (bar_take && (open_slot == TAG_W'(s))),
            .mask_in  (eff_mask(bar_kind, bar_mask)),
            .ld_cnt   (ld_cnt[s]),
            .st_cnt   (st_cnt[s]),
            .mask     (slot_mask[s])
        );
    end

    order_gate #(
        .CNT_W(CNT_W), .MAX_BAR(MAX_BAR), .NSLOT(NSLOT), .TAG_W(TAG_W), .NB_W(NB_W)
    ) u_gate (
        .head   (head),
        .nbar   (nbar),
        .ld_cnt (ld_cnt),
        .st_cnt (st_cnt),
        .mask   (slot_mask),
        .blk_ld (blk_ld),
        .blk_st (blk_st)
    );

    // Advance the barrier window: push on accept, pop the oldest on reclaim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            nbar <= '0;
        end else begin
            if (retire) head <= ring_add(head, 1);
            if (bar_take && !retire)      nbar <= nbar + 1'b1;
            else if (retire && !bar_take) nbar <= nbar - 1'b1;
        end
    end

    // Hold the weak-ordering sync state from issue until completion.
    always_ff @(posedge clk) begin
        if (!rst_n)         sync_busy <= 1'b0;
        else if (iss_sy)    sync_busy <= 1'b1;
        else if (sync_done) sync_busy <= 1'b0;
    end

    // Drive the issue permissions from registered state only.
    always_comb begin
        iss_tag    = open_slot;
        bar_ready  = (nbar != NB_LIMIT);
        ld_allow   = !sync_busy && !blk_ld && (ld_cnt[open_slot] != CNT_MAX);
        st_allow   = !sync_busy && !blk_st && (st_cnt[open_slot] != CNT_MAX);
        sync_allow = !sync_busy && all_idle;
    end

    assert_load_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ld |-> ld_allow);
    assert_store_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_st |-> st_allow);
    assert_sync_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_sy |-> sync_allow);
    assert_sync_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_busy |-> all_idle);
    assert_bar_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bar_valid |-> bar_ready);
    assert_window_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nbar <= NB_LIMIT);
endmodule

// File: tb/ord_barrier_unit_bench.sv
module ord_barrier_unit_bench;
    localparam int PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [1:0] iss_kind = 2'd0;
    logic [1:0] iss_tag;
    logic       bar_valid = 1'b0;
    logic [1:0] bar_kind = 2'd0;
    logic [3:0] bar_mask = 4'd0;
    logic       bar_ready;
    logic       ld_done = 1'b0;
    logic [1:0] ld_done_tag = 2'd0;
    logic       st_done = 1'b0;
    logic [1:0] st_done_tag = 2'd0;
    logic       sync_done = 1'b0;
    logic       ld_allow, st_allow, sync_allow;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit    ld;
        bit    st;
        bit    sy;
        bit    br;
        int    tag;
        string req;
    } exp_t;
    exp_t expq[$];

    always #(PER / 2) clk = ~clk;

    ord_barrier_unit u_ord_barrier_unit (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_kind(iss_kind),
        .iss_tag(iss_tag), .bar_valid(bar_valid), .bar_kind(bar_kind),
        .bar_mask(bar_mask), .bar_ready(bar_ready), .ld_done(ld_done),
        .ld_done_tag(ld_done_tag), .st_done(st_done), .st_done_tag(st_done_tag),
        .sync_done(sync_done), .ld_allow(ld_allow), .st_allow(st_allow),
        .sync_allow(sync_allow)
    );

    // Monitor: compare outputs a quarter period after each edge with the queued expectation.
    always @(posedge clk) begin
        #(PER / 4);
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            checks++;
            if (ld_allow !== e.ld || st_allow !== e.st || sync_allow !== e.sy ||
                bar_ready !== e.br || int'(iss_tag) != e.tag) begin
                failures++;
                $display("FAIL %s: got ld=%0b st=%0b sy=%0b br=%0b tag=%0d exp ld=%0b st=%0b sy=%0b br=%0b tag=%0d",
                         e.req, ld_allow, st_allow, sync_allow, bar_ready, iss_tag,
                         e.ld, e.st, e.sy, e.br, e.tag);
            end
        end
    end

    // Driver: queue the expectation for the coming edge, then release pulses.
    task automatic tick(bit l, bit s, bit y, bit b, int tag, string req);
        exp_t e;
        e.ld = l; e.st = s; e.sy = y; e.br = b; e.tag = tag; e.req = req;
        expq.push_back(e);
        @(negedge clk);
        iss_valid = 0; bar_valid = 0; ld_done = 0; st_done = 0; sync_done = 0;
    endtask

    task automatic op(int kind);
        iss_valid = 1; iss_kind = 2'(kind);
    endtask
    task automatic bar(int kind, logic [3:0] m);
        bar_valid = 1; bar_kind = 2'(kind); bar_mask = m;
    endtask
    task automatic ldc(int tag);
        ld_done = 1; ld_done_tag = 2'(tag);
    endtask
    task automatic stc(int tag);
        st_done = 1; st_done_tag = 2'(tag);
    endtask

    // Random-phase model state.
    int o_cls [64];
    int o_ep  [64];
    int o_tag [64];
    int o_dly [64];
    int n_out = 0;
    int b_ep  [1024];
    int b_m   [1024];
    int n_bar = 0;
    int cur_ep = 0;
    int sync_dly = -1;

    task automatic drop(int i);
        for (int j = i; j < n_out - 1; j++) begin
            o_cls[j] = o_cls[j+1]; o_ep[j] = o_ep[j+1];
            o_tag[j] = o_tag[j+1]; o_dly[j] = o_dly[j+1];
        end
        n_out--;
    endtask

    // Check a new issue of class x against every recorded barrier (R2, R3, R5).
    task automatic check_order(int x);
        bit bad;
        bad = 0;
        for (int b = 0; b < n_bar; b++)
            for (int i = 0; i < n_out; i++)
                if (o_ep[i] <= b_ep[b] && b_m[b][o_cls[i] * 2 + x]) bad = 1;
        if (sync_dly >= 0) bad = 1;
        checks++;
        if (bad) begin
            failures++;
            $display("FAIL R2: class %0d issued past an ordering barrier, got allowed=1 exp 0", x);
        end
    endtask

    initial begin
        #(PER * 200000);
        failures++;
        $display("FAIL watchdog: got running exp finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        tick(1, 1, 1, 1, 0, "R1 reset");

        // R2/R3/R6: mask LL|SL holds loads, stores pass
        op(0);                 tick(1, 1, 0, 1, 0, "R9 load issued");
        op(1);                 tick(1, 1, 0, 1, 0, "R9 store issued");
        bar(0, 4'b0101);       tick(0, 1, 0, 1, 1, "R3 stores pass LL|SL barrier");
        ldc(0);                tick(0, 1, 0, 1, 1, "R2 store->load still held");
        stc(0);                tick(1, 1, 1, 1, 1, "R6 release after last completion");
        tick(1, 1, 1, 1, 1, "R7 reclaimed idle");

        // R5: writes-only barrier
        op(1);                 tick(1, 1, 0, 1, 1, "R5 store");
        op(0);                 tick(1, 1, 0, 1, 1, "R5 load");
        bar(2, 4'b0000);       tick(1, 0, 0, 1, 2, "R5 writes-only holds stores");
        op(0);                 tick(1, 0, 0, 1, 2, "R5 loads unconstrained");
        ldc(1);                tick(1, 0, 0, 1, 2, "R5 stores still held");
        stc(1);                tick(1, 1, 0, 1, 2, "R6 stores released");
        ldc(2);                tick(1, 1, 1, 1, 2, "R7 window empty");

        // R4/R7: full barriers and window limit
        op(0);                 tick(1, 1, 0, 1, 2, "R4 load");
        bar(1, 4'b0000);       tick(0, 0, 0, 1, 0, "R4 full barrier");
        bar(1, 4'b0000);       tick(0, 0, 0, 0, 1, "R7 two pending");
        ldc(2);                tick(1, 1, 1, 0, 1, "R4 released");
        tick(1, 1, 1, 1, 1, "R7 oldest reclaimed");
        tick(1, 1, 1, 1, 1, "R7 second reclaimed");

        // R8: weak-ordering sync
        op(2);                 tick(0, 0, 0, 1, 1, "R8 sync blocks data");
        tick(0, 0, 0, 1, 1, "R8 sync held");
        sync_done = 1;         tick(1, 1, 1, 1, 1, "R8 sync done");

        // R9: free reordering between syncs
        op(0);                 tick(1, 1, 0, 1, 1, "R9 mix a");
        op(1);                 tick(1, 1, 0, 1, 1, "R9 mix b");
        op(0);                 tick(1, 1, 0, 1, 1, "R9 mix c");
        stc(1);                tick(1, 1, 0, 1, 1, "R9 out of order d");
        ldc(1);                tick(1, 1, 0, 1, 1, "R9 out of order e");
        ldc(1);                tick(1, 1, 1, 1, 1, "R9 drained");

        // R10: per-epoch load cap
        for (int i = 0; i < 15; i++) begin
            op(0);             tick(i < 14, 1, 0, 1, 1, "R10 load cap");
        end
        ldc(1);                tick(1, 1, 0, 1, 1, "R10 below cap");
        for (int i = 0; i < 14; i++) begin
            ldc(1);            tick(1, 1, i == 13, 1, 1, "R10 drain");
        end

        // R11: issue in the barrier cycle belongs to the closed epoch
        op(0); bar(0, 4'b0001); tick(0, 1, 0, 1, 2, "R11 same-cycle issue is earlier");
        ldc(1);                tick(1, 1, 1, 1, 2, "R11 completion by tag");
        tick(1, 1, 1, 1, 2, "R11 tag steady");

        // R2: load->store bit alone
        op(0);                 tick(1, 1, 0, 1, 2, "R2 load");
        bar(0, 4'b0010);       tick(1, 0, 0, 1, 0, "R2 load->store bit");
        ldc(2);                tick(1, 1, 1, 1, 0, "R2 released");
        tick(1, 1, 1, 1, 0, "R2 reclaimed");
        @(negedge clk);

        // Random stream with random completion delays
        for (int cyc = 0; cyc < 4000; cyc++) begin
            int r;
            int li;
            int si;
            li = -1; si = -1;
            for (int i = 0; i < n_out; i++) begin
                if (o_dly[i] <= 0 && o_cls[i] == 0 && li < 0) li = i;
                if (o_dly[i] <= 0 && o_cls[i] == 1 && si < 0) si = i;
            end
            if (li >= 0) begin
                ld_done = 1; ld_done_tag = 2'(o_tag[li]);
                drop(li);
                if (si > li) si--;
            end
            if (si >= 0) begin
                st_done = 1; st_done_tag = 2'(o_tag[si]);
                drop(si);
            end
            for (int i = 0; i < n_out; i++) o_dly[i]--;
            if (sync_dly == 0) begin sync_done = 1; sync_dly = -1; end
            else if (sync_dly > 0) sync_dly--;

            r = $urandom_range(0, 99);
            if (r < 35 && ld_allow && n_out < 60) begin
                check_order(0);
                iss_valid = 1; iss_kind = 2'd0;
                o_cls[n_out] = 0; o_ep[n_out] = cur_ep; o_tag[n_out] = int'(iss_tag);
                o_dly[n_out] = $urandom_range(0, 6); n_out++;
            end else if (r < 70 && st_allow && n_out < 60) begin
                check_order(1);
                iss_valid = 1; iss_kind = 2'd1;
                o_cls[n_out] = 1; o_ep[n_out] = cur_ep; o_tag[n_out] = int'(iss_tag);
                o_dly[n_out] = $urandom_range(0, 6); n_out++;
            end else if (r < 73 && sync_allow) begin
                checks++;
                if (n_out != 0 || sync_dly >= 0) begin
                    failures++;
                    $display("FAIL R8: sync allowed with %0d outstanding, exp 0", n_out);
                end
                iss_valid = 1; iss_kind = 2'd2;
                sync_dly = $urandom_range(0, 3);
            end
            if ($urandom_range(0, 99) < 10 && bar_ready && n_bar < 1024) begin
                int k;
                logic [3:0] m;
                k = $urandom_range(0, 2);
                m = 4'($urandom_range(0, 15));
                bar_valid = 1; bar_kind = 2'(k); bar_mask = m;
                b_ep[n_bar] = cur_ep;
                b_m[n_bar] = (k == 1) ? 15 : (k == 2) ? 8 : int'(m);
                n_bar++;
                cur_ep++;
            end
            @(negedge clk);
            iss_valid = 0; bar_valid = 0; ld_done = 0; st_done = 0; sync_done = 0;
        end

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule